// File: doc/BRIEF.md
# Dual Cascadable Countdown Timer

This peripheral holds two identical 32-bit down-counters behind an APB register port. Software gives each counter a start value, chooses one-shot or periodic operation, and starts it. A counter that runs moves one step toward zero on every clock. When it gets to zero it raises a status flag. The matching interrupt line carries that flag when interrupts are enabled for the counter. One interrupt line per timer feeds both the processor and the fabric.

A mode bit joins the two counters into a single 64-bit down-counter. In that mode the 64-bit counter has its own control, status and interrupt line, and the per-timer 32-bit registers do nothing. The 64-bit count value is read one word at a time. Reading the low word also snapshots the high word, so the high-word read that follows gives a matching pair.

Register map (byte offsets). Timer k (k = 0, 1) sits at base 0x10*k, with START at +0x0, COUNT (read-only) at +0x4, CTRL at +0x8 and FLAG at +0xC. CASCADE is at 0x20. The 64-bit counter registers are START_HI at 0x24, START_LO at 0x28, COUNT_HI at 0x2C, COUNT_LO at 0x30, CTRL64 at 0x34 and FLAG64 at 0x38. The CTRL bits are: bit0 run, bit1 interrupt enable, bit2 one-shot (0 = periodic), and bit3 restart, which is write-only and always reads 0. FLAG bit0 is the status flag, and writing 1 to it clears it. CASCADE bit0 set selects 64-bit mode.

Top module: `dual_cascade_timer`

## Requirements
- R1: After reset every register reads 0 and all interrupt outputs are low. Any address outside the map reads 0.
- R2: A running 32-bit counter decreases by exactly one each clock while it is above zero.
- R3: In periodic mode, a counter at zero reloads its START value on the next clock and keeps counting.
- R4: In one-shot mode, a counter that reaches zero stays at zero and its CTRL run bit clears (CTRL reads back with bit0 = 0).
- R5: The FLAG bit is set when a running counter steps from 1 to 0, whether or not interrupts are enabled. The interrupt line is high exactly when both FLAG and the interrupt enable are set.
- R6: Writing 1 to FLAG bit0 clears the flag and drops the interrupt line.
- R7: Writing START copies the value into the counter at once, even while the counter runs.
- R8: A CTRL write with bit3 set reloads the counter from START and keeps the written mode bits. Bit3 reads back as 0.
- R9: In 64-bit mode the two words count as one value: a borrow out of the low word decrements the high word.
- R10: In 64-bit mode, writes to the 32-bit timer registers have no effect, those registers read 0, and the 32-bit interrupt lines stay low.
- R11: Reading COUNT_LO captures the high word, and a later COUNT_HI read returns that captured value.
- R12: The 64-bit counter sets FLAG64 on reaching zero and drives its own interrupt line, gated by CTRL64 bit1.
- R13: Clearing the run bit freezes the count at its current value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB enable (access phase) |
| pwrite | input | 1 | APB write strobe |
| paddr | input | AW | APB byte address |
| pwdata | input | DW | APB write data |
| prdata | output | DW | APB read data |
| pready | output | 1 | APB ready, always high |
| irq_t1 | output | 1 | Timer 0 interrupt |
| irq_t2 | output | 1 | Timer 1 interrupt |
| irq_t64 | output | 1 | 64-bit counter interrupt |

## Verification
The hardest state to reach is a borrow across the word boundary of the 64-bit counter while the high-word snapshot is being read. The stimulus loads a 64-bit value of 2^32 + 2 and starts the counter. It then issues the COUNT_LO read at the exact bus cycle where the low word is zero and the high word is about to decrement. The COUNT_HI read that follows must return the old high word, while the live count has already moved past the borrow. All read results go through an expected-value queue, with every expected count worked out from the fixed three-cycle spacing of the bus transactions.

// File: rtl/dual_cascade_timer.sv
module dual_cascade_timer #(
  parameter int AW = 8,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          psel,
  input  logic          penable,
  input  logic          pwrite,
  input  logic [AW-1:0] paddr,
  input  logic [DW-1:0] pwdata,
  output logic [DW-1:0] prdata,
  output logic          pready,
  output logic          irq_t1,
  output logic          irq_t2,
  output logic          irq_t64
);
  localparam int NT = 2;
  localparam logic [AW-1:0] A_MODE = AW'(8'h20);
  localparam logic [AW-1:0] A_LDHI = AW'(8'h24);
  localparam logic [AW-1:0] A_LDLO = AW'(8'h28);
  localparam logic [AW-1:0] A_VHI  = AW'(8'h2C);
  localparam logic [AW-1:0] A_VLO  = AW'(8'h30);
  localparam logic [AW-1:0] A_C64  = AW'(8'h34);
  localparam logic [AW-1:0] A_S64  = AW'(8'h38);
  localparam logic [DW-1:0] ONE    = DW'(1);

  logic          wr, rd, cascade;
  logic [DW-1:0] cnt [NT];
  logic [DW-1:0] ld  [NT];
  logic [NT-1:0] run, ie, os, st;
  logic          run64, ie64, os64, st64;
  logic [DW-1:0] hi_snap;
  logic [2*DW-1:0] cnt64, ld64, nxt64;
  logic          wr_c64, tick64;

  assign pready = 1'b1;
  assign wr     = psel && penable && pwrite;
  assign rd     = psel && penable && !pwrite;
  assign cnt64  = {cnt[1], cnt[0]};
  assign ld64   = {ld[1], ld[0]};
  assign wr_c64 = wr && cascade && paddr == A_C64;
  assign tick64 = cascade && run64 && cnt64 == {{DW{1'b0}}, ONE};

  always_comb begin
    nxt64 = cnt64;
    if (wr_c64 && pwdata[3]) nxt64 = ld64;
    else if (run64) nxt64 = (cnt64 == '0) ? (os64 ? '0 : ld64) : cnt64 - 1'b1;
  end

  for (genvar i = 0; i < NT; i++) begin : g_tmr
    localparam logic [AW-1:0] BASE = AW'(i * 16);
    logic wr_ld, wr_ctl, wr_st, wr_ld64, tick;

    assign wr_ld   = wr && !cascade && paddr == BASE;
    assign wr_ctl  = wr && !cascade && paddr == BASE + AW'(8);
    assign wr_st   = wr && !cascade && paddr == BASE + AW'(12);
    assign wr_ld64 = wr && cascade && paddr == ((i == 1) ? A_LDHI : A_LDLO);
    assign tick    = !cascade && run[i] && cnt[i] == ONE;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cnt[i] <= '0;
        ld[i]  <= '0;
      end else begin
        if (wr_ld || wr_ld64) ld[i] <= pwdata;
        if (wr_ld || wr_ld64) cnt[i] <= pwdata;
        else if (wr_ctl && pwdata[3]) cnt[i] <= ld[i];
        else if (cascade) cnt[i] <= nxt64[i*DW +: DW];
        else if (run[i]) cnt[i] <= (cnt[i] == '0) ? (os[i] ? '0 : ld[i]) : cnt[i] - ONE;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        run[i] <= 1'b0;
        ie[i]  <= 1'b0;
        os[i]  <= 1'b0;
        st[i]  <= 1'b0;
      end else begin
        if (wr_ctl) {os[i], ie[i], run[i]} <= pwdata[2:0];
        else if (tick && os[i]) run[i] <= 1'b0;
        if (tick) st[i] <= 1'b1;
        else if (wr_st && pwdata[0]) st[i] <= 1'b0;
      end
    end

    p_count_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!cascade && run[i] && cnt[i] > ONE && !wr) |=> cnt[i] == $past(cnt[i]) - ONE);
    p_reload_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!cascade && run[i] && !os[i] && cnt[i] == '0 && !wr) |=> cnt[i] == $past(ld[i]));
    p_oneshot_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!cascade && run[i] && os[i] && cnt[i] == ONE && !wr) |=> !run[i] && cnt[i] == '0 && st[i]);
    p_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
      (!cascade && !run[i] && !wr) |=> $stable(cnt[i]));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cascade <= 1'b0;
      run64   <= 1'b0;
      ie64    <= 1'b0;
      os64    <= 1'b0;
      st64    <= 1'b0;
      hi_snap <= '0;
    end else begin
      if (wr && paddr == A_MODE) cascade <= pwdata[0];
      if (wr_c64) {os64, ie64, run64} <= pwdata[2:0];
      else if (tick64 && os64) run64 <= 1'b0;
      if (tick64) st64 <= 1'b1;
      else if (wr && cascade && paddr == A_S64 && pwdata[0]) st64 <= 1'b0;
      if (rd && cascade && paddr == A_VLO) hi_snap <= cnt[1];
    end
  end

  always_comb begin
    prdata = '0;
    if (!cascade) begin
      for (int i = 0; i < NT; i++) begin
        if (paddr == AW'(i * 16))       prdata = ld[i];
        if (paddr == AW'(i * 16 + 4))   prdata = cnt[i];
        if (paddr == AW'(i * 16 + 8))   prdata = DW'({os[i], ie[i], run[i]});
        if (paddr == AW'(i * 16 + 12))  prdata = DW'(st[i]);
      end
    end else begin
      case (paddr)
        A_LDHI:  prdata = ld[1];
        A_LDLO:  prdata = ld[0];
        A_VHI:   prdata = hi_snap;
        A_VLO:   prdata = cnt[0];
        A_C64:   prdata = DW'({os64, ie64, run64});
        A_S64:   prdata = DW'(st64);
        default: prdata = '0;
      endcase
    end
    if (paddr == A_MODE) prdata = DW'(cascade);
  end

  assign irq_t1  = st[0] && ie[0];
  assign irq_t2  = st[1] && ie[1];
  assign irq_t64 = st64 && ie64;

  p_borrow_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cascade && run64 && cnt[0] == '0 && cnt[1] != '0 && !wr)
      |=> cnt[0] == '1 && cnt[1] == $past(cnt[1]) - ONE);
  p_clear64_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && cascade && paddr == A_S64 && pwdata[0] && !tick64) |=> !irq_t64);
  p_quiet32_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cascade && !irq_t1 && !irq_t2) |=> (!irq_t1 && !irq_t2));
endmodule

// File: tb/dual_cascade_timer_test.sv
module dual_cascade_timer_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [7:0] paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata;
  logic pready, irq_t1, irq_t2, irq_t64;
  int total = 0, bad = 0;
  bit done = 1'b0;
  logic [31:0] exp_q[$];
  string tag_q[$];

  always #2 clk = ~clk;

  dual_cascade_timer uut (.clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable),
    .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pready(pready),
    .irq_t1(irq_t1), .irq_t2(irq_t2), .irq_t64(irq_t64));

  task automatic xfer(input logic w, input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); psel = 1'b1; pwrite = w; paddr = a; pwdata = d;
    @(negedge clk); penable = 1'b1;
    @(negedge clk); psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    xfer(1'b1, a, d);
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] e, input string tag);
    exp_q.push_back(e); tag_q.push_back(tag);
    xfer(1'b0, a, '0);
  endtask

  task automatic chk(input logic got, input logic e, input string tag);
    total++;
    if (got !== e) begin bad++; $display("FAIL %s got=%0h exp=%0h", tag, got, e); end
  endtask

  always @(negedge clk) begin
    #1;
    if (psel && penable && !pwrite && exp_q.size() > 0) begin
      logic [31:0] e;
      string t;
      e = exp_q.pop_front(); t = tag_q.pop_front();
      total++;
      if (prdata !== e) begin bad++; $display("FAIL %s got=%0h exp=%0h", t, prdata, e); end
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog got=hang exp=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk); rst_n = 1'b1;
    chk(irq_t1, 1'b0, "R1 irq_t1"); chk(irq_t2, 1'b0, "R1 irq_t2"); chk(irq_t64, 1'b0, "R1 irq_t64");
    rd(8'h00, 0, "R1 start"); rd(8'h04, 0, "R1 count"); rd(8'h08, 0, "R1 ctrl");
    rd(8'h0C, 0, "R1 flag"); rd(8'h20, 0, "R1 mode"); rd(8'h3C, 0, "R1 unmapped");
    // one-shot with interrupt on timer 0
    wr(8'h00, 3); wr(8'h08, 7);
    repeat (6) @(negedge clk);
    rd(8'h04, 0, "R4 holds zero"); rd(8'h08, 6, "R4 run cleared");
    rd(8'h0C, 1, "R5 flag set"); chk(irq_t1, 1'b1, "R5 irq_t1 high");
    wr(8'h0C, 1); chk(irq_t1, 1'b0, "R6 irq_t1 cleared"); rd(8'h0C, 0, "R6 flag cleared");
    // periodic: count and reload
    wr(8'h00, 5); wr(8'h08, 1);
    rd(8'h04, 3, "R2 countdown"); rd(8'h04, 0, "R2 reached zero"); rd(8'h04, 3, "R3 reload");
    // load while running, then stop
    wr(8'h00, 1000); rd(8'h04, 998, "R7 load copies");
    wr(8'h08, 0); rd(8'h04, 994, "R13 frozen"); rd(8'h04, 994, "R13 still frozen");
    wr(8'h08, 32'hC); rd(8'h08, 4, "R8 mode kept"); rd(8'h04, 1000, "R8 reloaded");
    // timer 1: flag without enable
    wr(8'h10, 2); wr(8'h18, 5);
    repeat (6) @(negedge clk);
    chk(irq_t2, 1'b0, "R5 masked irq_t2"); rd(8'h1C, 1, "R5 flag w/o enable");
    wr(8'h18, 2); chk(irq_t2, 1'b1, "R5 enable exposes flag");
    wr(8'h1C, 1); chk(irq_t2, 1'b0, "R6 irq_t2 cleared");
    // 64-bit mode
    wr(8'h20, 1); wr(8'h24, 1); wr(8'h28, 2); wr(8'h34, 3);
    rd(8'h30, 0, "R9 low word"); rd(8'h2C, 1, "R11 snapshot hi");
    wr(8'h34, 0); rd(8'h30, 32'hFFFF_FFF9, "R9 borrow low"); rd(8'h2C, 0, "R9 borrow high");
    wr(8'h00, 55); wr(8'h08, 1);
    rd(8'h00, 0, "R10 start ignored"); rd(8'h30, 32'hFFFF_FFF9, "R10 count untouched");
    chk(irq_t1, 1'b0, "R10 irq_t1 low");
    wr(8'h24, 0); wr(8'h28, 2); wr(8'h34, 7);
    repeat (6) @(negedge clk);
    chk(irq_t64, 1'b1, "R12 irq_t64 high"); chk(irq_t1, 1'b0, "R12 irq_t1 low");
    rd(8'h38, 1, "R12 flag64"); rd(8'h34, 6, "R4 one-shot 64 stopped");
    wr(8'h38, 1); chk(irq_t64, 1'b0, "R6 irq_t64 cleared");
    repeat (3) @(negedge clk);
    if (exp_q.size() != 0) begin bad++; total++; $display("FAIL queue got=%0d exp=0", exp_q.size()); end
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule